// File: doc/BRIEF.md
# Fourth-Order Transposed IIR Section with Input Pre-Scaling

This block filters a stream of signed 12-bit converter samples through a fourth-order recursive filter built in transposed direct form. Each accepted sample is first sign-extended and arithmetically shifted right by a fixed amount so that it fits the 16-bit two's-complement arithmetic with headroom. The sample then feeds a chain of four delay registers. Each register loads a weighted copy of the input, minus a weighted copy of the current output, plus the contents of the register after it.

Products are kept at full width and summed at an extended width. The sum for each register is rounded once and stored modulo 2^16, so intermediate wrap-around is tolerated. The output node is the only point checked against the 16-bit range, and a flag reports when it falls outside. The nine coefficients are static inputs in signed Q2.14. They are normally driven from configuration registers elsewhere and may be changed between samples.

Top module: `iir4_tdf`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four delay registers, `y_out`, `out_valid` and `ovf_flag` are cleared to zero at that edge.
- R2: An accepted sample s is converted to u = sign_extend16(s) >>> 3. For example, 12'h7FF gives 255, 12'h800 gives -256, 12'hFFF gives -1 and 12'h007 gives 0.
- R3: Coefficients are signed Q2.14. Numerator coefficient b_k sits in `coef_b[16k+15:16k]` for k = 0..4. Denominator coefficient a_k sits in `coef_a[16(k-1)+15:16(k-1)]` for k = 1..4. The output is y = rnd(b0*u + s1*2^14). The register updates are s_k' = wrap16(rnd(b_k*u - a_k*y16 + s_{k+1}*2^14)), with s_5 = 0.
- R4: Rounding is rnd(v) = floor((v + 2^13) / 2^14), applied once per sum, after the whole sum is formed.
- R5: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `y_out` and `ovf_flag` for that sample appear in the same cycle.
- R6: A cycle with `in_valid` low leaves the delay registers, `y_out` and `ovf_flag` unchanged, whatever `in_sample` holds.
- R7: The 16-bit output y16 is the low 16 bits of the rounded output sum, taken modulo 2^16. This wrapped value is both `y_out` and the y16 fed back into the register updates. Delay registers likewise keep only the low 16 bits of their rounded sums.
- R8: `ovf_flag` is set when the rounded output sum lies outside [-32768, 32767] and is cleared when it lies inside. It is updated once for each accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 12 | Signed converter sample |
| coef_b | input | 80 | Numerator coefficients b0..b4, Q2.14 |
| coef_a | input | 64 | Denominator coefficients a1..a4, Q2.14 |
| out_valid | output | 1 | Output sample strobe |
| y_out | output | 16 | Signed filter output |
| ovf_flag | output | 1 | Output node out of range for this sample |

## Verification
The assertions rely on the reset being low at the first clock edge, and on `in_valid` being a clean 0/1 value at every edge. Coefficients and samples are unconstrained in value. The stimulus therefore drives every input at the falling edge only and holds `rst_n` low from time zero. It draws coefficients from arbitrary Q2.14 values, including values that make the loop grow, so that the wrap-around and the flag are both exercised.

// File: rtl/iir4_tdf.sv
module iir4_tdf #(
  parameter int IN_W      = 12,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int ORDER     = 4,
  parameter int PRE_SHIFT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [IN_W-1:0]           in_sample,
  input  logic [(ORDER+1)*CW-1:0]   coef_b,
  input  logic [ORDER*CW-1:0]       coef_a,
  output logic                      out_valid,
  output logic [DW-1:0]             y_out,
  output logic                      ovf_flag
);
  localparam int FRAC  = CW - 2;
  localparam int ACC_W = DW + CW + 3;
  localparam int RW    = ACC_W - FRAC;
  localparam logic signed [ACC_W-1:0] RND =
    {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [DW-1:0]    u_ext, u_s;
  logic signed [DW-1:0]    st [1:ORDER];
  logic signed [CW-1:0]    b_c [0:ORDER];
  logic signed [CW-1:0]    a_c [1:ORDER];
  logic signed [ACC_W-1:0] acc_y;
  logic signed [RW-1:0]    y_full;
  logic signed [DW-1:0]    y_w;
  logic                    ovf_now;

  assign u_ext = {{(DW-IN_W){in_sample[IN_W-1]}}, in_sample};
  assign u_s   = u_ext >>> PRE_SHIFT;

  for (genvar k = 0; k <= ORDER; k++) begin : g_b
    assign b_c[k] = coef_b[k*CW +: CW];
  end
  for (genvar k = 1; k <= ORDER; k++) begin : g_a
    assign a_c[k] = coef_a[(k-1)*CW +: CW];
  end

  assign acc_y   = ACC_W'(b_c[0]) * ACC_W'(u_s) + (ACC_W'(st[1]) <<< FRAC) + RND;
  assign y_full  = RW'(acc_y >>> FRAC);
  assign y_w     = y_full[DW-1:0];
  assign ovf_now = (y_full[RW-1:DW-1] != '0) && (y_full[RW-1:DW-1] != '1);

  for (genvar k = 1; k <= ORDER; k++) begin : g_st
    logic signed [DW-1:0]    tail;
    logic signed [ACC_W-1:0] acc;
    if (k == ORDER) begin : g_last
      assign tail = '0;
    end else begin : g_mid
      assign tail = st[k+1];
    end
    assign acc = ACC_W'(b_c[k]) * ACC_W'(u_s) - ACC_W'(a_c[k]) * ACC_W'(y_w)
               + (ACC_W'(tail) <<< FRAC) + RND;
    always_ff @(posedge clk) begin
      if (!rst_n)        st[k] <= '0;
      else if (in_valid) st[k] <= DW'(acc >>> FRAC);
    end
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(st[k])); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y_out     <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y_out    <= y_w;
        ovf_flag <= ovf_now;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && y_out == '0 && !ovf_flag)); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(y_out) && $stable(ovf_flag))); // R6
  AST_FLAG_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) || $fell(ovf_flag)) |-> out_valid); // R8
endmodule

// File: tb/iir4_tdf_bench.sv
module iir4_tdf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic [79:0] coef_b = '0;
  logic [63:0] coef_a = '0;
  logic        out_valid;
  logic [15:0] y_out;
  logic        ovf_flag;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  longint m_st [1:5];
  longint m_y;
  bit     m_ovf;
  bit     seen_ovf;

  always #5 clk = ~clk;

  iir4_tdf u_iir4_tdf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_b(coef_b), .coef_a(coef_a), .out_valid(out_valid),
    .y_out(y_out), .ovf_flag(ovf_flag)
  );

  function automatic longint rnd14(longint v);
    return (v + 64'sd8192) >>> 14;
  endfunction

  function automatic longint wrap16(longint v);
    longint w = v & 64'hFFFF;
    if (w >= 32768) w = w - 65536;
    return w;
  endfunction

  function automatic longint sx16(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint prescale(logic [11:0] s);
    longint v = longint'($signed(s));
    return v >>> 3;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 1; k <= 5; k++) m_st[k] = 0;
    m_y = 0;
    m_ovf = 1'b0;
  endtask

  task automatic model_step(logic [11:0] s);
    longint u, yf, ak, bk;
    longint nx [1:4];
    u  = prescale(s);
    yf = rnd14(sx16(coef_b[15:0]) * u + m_st[1] * 16384);
    m_y = wrap16(yf);
    m_ovf = (yf > 32767) || (yf < -32768);
    for (int k = 1; k <= 4; k++) begin
      bk = sx16(coef_b[k*16 +: 16]);
      ak = sx16(coef_a[(k-1)*16 +: 16]);
      nx[k] = wrap16(rnd14(bk * u - ak * m_y + m_st[k+1] * 16384));
    end
    for (int k = 1; k <= 4; k++) m_st[k] = nx[k];
  endtask

  task automatic send(logic [11:0] s, int gap, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = s;
    model_step(s);
    @(negedge clk);
    in_valid = 1'b0;
    in_sample = 12'($urandom);
    check("R5", "out_valid", longint'(out_valid), 1);
    check(req, "y_out", sx16(y_out), m_y);
    check("R8", "ovf_flag", longint'(ovf_flag), longint'(m_ovf));
    if (ovf_flag) seen_ovf = 1'b1;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_sample = 12'($urandom);
      check("R5", "idle out_valid", longint'(out_valid), 0);
      check("R6", "idle y_out", sx16(y_out), m_y);
    end
  endtask

  task automatic set_coefs(longint b0, longint b1, longint b2, longint b3, longint b4,
                           longint a1, longint a2, longint a3, longint a4);
    coef_b = {16'(b4), 16'(b3), 16'(b2), 16'(b1), 16'(b0)};
    coef_a = {16'(a4), 16'(a3), 16'(a2), 16'(a1)};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset out_valid", longint'(out_valid), 0);
    check("R1", "reset y_out", sx16(y_out), 0);
    check("R1", "reset ovf_flag", longint'(ovf_flag), 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL R5 watchdog actual %0d expected below %0d", cycles, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    seen_ovf = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "initial out_valid", longint'(out_valid), 0);
    check("R1", "initial y_out", sx16(y_out), 0);
    rst_n = 1'b1;

    // R2: unity pass-through exposes the pre-shift
    set_coefs(16384, 0, 0, 0, 0, 0, 0, 0, 0);
    send(12'h7FF, 0, "R2");
    send(12'h800, 0, "R2");
    send(12'hFFF, 0, "R2");
    send(12'h007, 0, "R2");
    send(12'h008, 1, "R2");
    check("R2", "0x7FF scaled", prescale(12'h7FF), 255);

    // R3: pure delays through the register chain
    set_coefs(0, 0, 0, 0, 16384, 0, 0, 0, 0);
    send(12'h400, 0, "R3");
    for (int i = 0; i < 4; i++) send(12'h000, 0, "R3");
    check("R3", "delayed impulse", sx16(y_out), 128);

    // R4: half-LSB rounding (0.5 * 1 rounds up, 0.5 * -1 rounds to 0)
    do_reset();
    set_coefs(8192, 0, 0, 0, 0, 0, 0, 0, 0);
    send(12'h008, 0, "R4");
    check("R4", "round +0.5", sx16(y_out), 1);
    send(12'hFF8, 0, "R4");
    check("R4", "round -0.5", sx16(y_out), 0);

    // R6: idle cycles with changing sample leave state alone
    set_coefs(10000, 6000, -3000, 2000, 1000, -8000, 3000, -1000, 500);
    for (int i = 0; i < 6; i++) send(12'($urandom), 3, "R6");

    // R7/R8: growing loop forces wrap and overflow, then recovers
    do_reset();
    set_coefs(32767, 0, 0, 0, 0, -16384, 0, 0, 0);
    for (int i = 0; i < 140; i++) send(12'h7FF, 0, "R7");
    check("R8", "overflow seen", longint'(seen_ovf), 1);
    set_coefs(0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) send(12'h123, 0, "R8");
    check("R8", "flag cleared", longint'(ovf_flag), 0);

    // R1: reset in the middle of a run clears the chain
    set_coefs(9000, 4000, 4000, 4000, 4000, -4000, 2000, 0, 0);
    for (int i = 0; i < 5; i++) send(12'($urandom), 0, "R3");
    do_reset();
    set_coefs(0, 16384, 0, 0, 0, 0, 0, 0, 0);
    send(12'h000, 0, "R1");
    check("R1", "state cleared", sx16(y_out), 0);

    // R3/R7/R8: random coefficients and samples
    for (int blk = 0; blk < 40; blk++) begin
      coef_b = {16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)};
      coef_a = {16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)};
      if (blk % 2 == 0) begin
        coef_b = {5{16'($signed(16'($urandom)) >>> 2)}};
        coef_a = {4{16'($signed(16'($urandom)) >>> 3)}};
      end
      for (int i = 0; i < 40; i++) send(12'($urandom), int'($urandom % 3), "R3");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule